// File: doc/BRIEF.md
# CAS-before-RAS DRAM Refresh Sequencer

This block runs one CAS-before-RAS refresh cycle on a shared 32-bit address/data bus each time it accepts a refresh request. While the cycle is active it drives a marker word onto the bus. The marker holds the refresh address counter in the upper half, zeros in the middle and a fixed status code in the low nibble. It also steps the four column strobes and the single row strobe through the refresh pattern. All strobe spacing is counted in quarter-cycle ticks (`qtick`), so the same logic serves any bus clock ratio. An optional stretch adds one quarter-cycle to the time that both strobes are low.

The request side follows valid/ready rules. A request is taken on a clock where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle. A requester may hold `req_valid` high for as long as it likes: while the sequencer is busy, the request simply waits. If `req_valid` is still high when the sequencer returns to idle, another refresh cycle starts. The request carries no payload. The refresh address counter can be loaded through a plain write port. After each finished cycle the counter advances by one.

Top module: `cbr_refresh_seq`

## Requirements
- R1: After reset the block is in this state: `ras_n` high, all `cas_n` bits high, `bus_oe` low, `bus_out` zero, `done` low, `req_ready` high, and the refresh address counter holds 0.
- R2: A request is accepted only while `req_ready` is high. `req_ready` is low from the clock after acceptance until the clock after `done`. `req_valid` held high while busy does not start a second cycle, and no strobe or bus change comes from it.
- R3: From the clock after acceptance until the row strobe returns high, `bus_oe` is high and `bus_out` is held stable. `bus_out[31:16]` equals the counter value at acceptance, `bus_out[15:4]` is zero and `bus_out[3:0]` is 4'b0011. Outside that window `bus_oe` is low and `bus_out` is zero.
- R4: On the clock after acceptance all four `cas_n` bits go low together while `ras_n` stays high. The four `cas_n` bits always carry the same value.
- R5: `ras_n` falls after exactly 2 `qtick` pulses have been seen with the column strobes low and the row strobe high.
- R6: The column strobes return high after exactly 4 `qtick` pulses with both strobes low, or 5 pulses when stretch is in effect.
- R7: `ras_n` returns high after exactly 2 `qtick` pulses with the column strobes high and the row strobe low.
- R8: `stretch_en` is sampled only on the accepting clock. Changing it during a cycle has no effect on that cycle.
- R9: `done` is high for exactly one clock: the first clock on which `ras_n` is high again, with all strobes high.
- R10: On the clock after `done` the counter advances by one, and it wraps from 16'hFFFF to 16'h0000.
- R11: A write (`wr_en` high) loads `wr_data` into the counter on the next clock. A write on the same clock as the advance of R10 wins over the advance. A write during a cycle leaves that cycle's bus word unchanged, and the advance then applies to the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qtick | input | 1 | Quarter-cycle tick, one clock wide per quarter |
| req_valid | input | 1 | Refresh request valid |
| req_ready | output | 1 | Sequencer idle and able to accept |
| stretch_en | input | 1 | Add one quarter-cycle to the both-low phase |
| wr_en | input | 1 | Load the refresh address counter |
| wr_data | input | 16 | Value to load |
| bus_out | output | 32 | Refresh marker word |
| bus_oe | output | 1 | Bus drive enable |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 4 | Column strobes, active low |
| done | output | 1 | One-clock pulse at the end of a cycle |

## Verification
Two functions can land on the same clock edge: a counter write and the post-cycle advance. The bench provokes this by raising `wr_en` on the clock where `done` is seen. It then judges the outcome from the next refresh cycle's bus word, which must show the written value rather than the advanced one. A second case writes in the middle of a cycle. There the current bus word must not change, and the following cycle must show the written value plus one.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_CAS_LOW  = 3'd1,
    PH_RAS_LOW  = 3'd2,
    PH_CAS_HIGH = 3'd3,
    PH_RAS_HIGH = 3'd4
  } phase_e;

  function automatic phase_e phase_after(input phase_e cur);
    case (cur)
      PH_CAS_LOW:  return PH_RAS_LOW;
      PH_RAS_LOW:  return PH_CAS_HIGH;
      PH_CAS_HIGH: return PH_RAS_HIGH;
      default:     return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/cbr_phase_fsm.sv
module cbr_phase_fsm
  import cbr_refresh_pkg::*;
#(
  parameter int CNT_W           = 3,
  parameter int CAS_TO_RAS_Q    = 2,
  parameter int RAS_TO_CAS_Q    = 4,
  parameter int CAS_TO_RASREL_Q = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   qtick,
  input  logic   start,
  input  logic   stretch_en,
  output phase_e phase
);

  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               stretch_q;
  logic [CNT_W-1:0]   dwell;
  logic               last_tick;

  always_comb begin
    case (phase_q)
      PH_CAS_LOW:  dwell = CNT_W'(CAS_TO_RAS_Q);
      PH_RAS_LOW:  dwell = CNT_W'(RAS_TO_CAS_Q) + CNT_W'(stretch_q);
      PH_CAS_HIGH: dwell = CNT_W'(CAS_TO_RASREL_Q);
      default:     dwell = CNT_W'(1);
    endcase
  end

  assign last_tick = (cnt_q == dwell - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      stretch_q <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q   <= PH_CAS_LOW;
            cnt_q     <= '0;
            stretch_q <= stretch_en;
          end
        end
        PH_CAS_LOW, PH_RAS_LOW, PH_CAS_HIGH: begin
          if (qtick) begin
            if (last_tick) begin
              phase_q <= phase_after(phase_q);
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        default: begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/cbr_addr_reg.sv
module cbr_addr_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              bump,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] addr_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_r <= '0;
    end else if (wr_en) begin
      addr_r <= wr_data;
    end else if (bump) begin
      addr_r <= addr_r + ADDR_W'(1);
    end
  end

  assign addr = addr_r;

endmodule

// File: rtl/cbr_bus_drive.sv
module cbr_bus_drive
  import cbr_refresh_pkg::*;
#(
  parameter int                BUS_W       = 32,
  parameter int                ADDR_W      = 16,
  parameter int                NUM_CAS     = 4,
  parameter int                STATUS_W    = 4,
  parameter logic [STATUS_W-1:0] STATUS_CODE = 4'b0011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [ADDR_W-1:0]  addr,
  input  phase_e             phase,
  output logic [BUS_W-1:0]   bus_out,
  output logic               bus_oe,
  output logic               ras_n,
  output logic [NUM_CAS-1:0] cas_n
);

  localparam int PAD_W = BUS_W - ADDR_W - STATUS_W;

  logic [ADDR_W-1:0] snap_q;
  logic              cas_act;
  logic              ras_act;
  logic [BUS_W-1:0]  marker;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (capture) begin
      snap_q <= addr;
    end
  end

  assign cas_act = (phase == PH_CAS_LOW) || (phase == PH_RAS_LOW);
  assign ras_act = (phase == PH_RAS_LOW) || (phase == PH_CAS_HIGH);
  assign bus_oe  = cas_act || ras_act;

  generate
    if (PAD_W > 0) begin : g_pad
      assign marker = {snap_q, {PAD_W{1'b0}}, STATUS_CODE};
    end else begin : g_nopad
      assign marker = {snap_q, STATUS_CODE};
    end
  endgenerate

  assign bus_out = bus_oe ? marker : '0;
  assign ras_n   = ~ras_act;

  generate
    for (genvar i = 0; i < NUM_CAS; i++) begin : g_cas
      assign cas_n[i] = ~cas_act;
    end
  endgenerate

endmodule

// File: rtl/cbr_refresh_seq.sv
module cbr_refresh_seq
  import cbr_refresh_pkg::*;
#(
  parameter int                  ADDR_W          = 16,
  parameter int                  BUS_W           = 32,
  parameter int                  NUM_CAS         = 4,
  parameter int                  STATUS_W        = 4,
  parameter logic [STATUS_W-1:0] STATUS_CODE     = 4'b0011,
  parameter int                  CAS_TO_RAS_Q    = 2,
  parameter int                  RAS_TO_CAS_Q    = 4,
  parameter int                  CAS_TO_RASREL_Q = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               qtick,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               stretch_en,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_data,
  output logic [BUS_W-1:0]   bus_out,
  output logic               bus_oe,
  output logic               ras_n,
  output logic [NUM_CAS-1:0] cas_n,
  output logic               done
);

  localparam int MAX_A  = (CAS_TO_RAS_Q > CAS_TO_RASREL_Q) ? CAS_TO_RAS_Q : CAS_TO_RASREL_Q;
  localparam int MAX_DW = ((RAS_TO_CAS_Q + 1) > MAX_A) ? (RAS_TO_CAS_Q + 1) : MAX_A;
  localparam int CNT_W  = $clog2(MAX_DW + 1);

  phase_e            phase;
  logic              start;
  logic [ADDR_W-1:0] addr_q;

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;
  assign done      = (phase == PH_RAS_HIGH);

  cbr_phase_fsm #(
    .CNT_W          (CNT_W),
    .CAS_TO_RAS_Q   (CAS_TO_RAS_Q),
    .RAS_TO_CAS_Q   (RAS_TO_CAS_Q),
    .CAS_TO_RASREL_Q(CAS_TO_RASREL_Q)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .qtick     (qtick),
    .start     (start),
    .stretch_en(stretch_en),
    .phase     (phase)
  );

  cbr_addr_reg #(
    .ADDR_W(ADDR_W)
  ) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .bump   (done),
    .addr   (addr_q)
  );

  cbr_bus_drive #(
    .BUS_W      (BUS_W),
    .ADDR_W     (ADDR_W),
    .NUM_CAS    (NUM_CAS),
    .STATUS_W   (STATUS_W),
    .STATUS_CODE(STATUS_CODE)
  ) u_bus (
    .clk    (clk),
    .rst_n  (rst_n),
    .capture(start),
    .addr   (addr_q),
    .phase  (phase),
    .bus_out(bus_out),
    .bus_oe (bus_oe),
    .ras_n  (ras_n),
    .cas_n  (cas_n)
  );

endmodule

// File: rtl/cbr_refresh_seq_chk.sv
module cbr_refresh_seq_chk #(
  parameter int                  ADDR_W      = 16,
  parameter int                  BUS_W       = 32,
  parameter int                  NUM_CAS     = 4,
  parameter int                  STATUS_W    = 4,
  parameter logic [STATUS_W-1:0] STATUS_CODE = 4'b0011
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_data,
  input logic [BUS_W-1:0]   bus_out,
  input logic               bus_oe,
  input logic               ras_n,
  input logic [NUM_CAS-1:0] cas_n,
  input logic               done,
  input logic [ADDR_W-1:0]  addr_q
);

  localparam int PAD_HI = BUS_W - ADDR_W - 1;

  // R4: column strobes move as one
  assert_cas_lockstep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n == '0) || (cas_n == '1));

  // R4: row strobe only falls with column strobes already low
  assert_cas_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (cas_n == '0) && ($past(cas_n) == '0));

  // R7: row strobe released after column strobes
  assert_ras_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (cas_n == '1) && ($past(cas_n) == '1));

  // R9: done is a single clock
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: done coincides with row strobe release
  assert_done_at_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(ras_n));

  // R3: marker word fields
  assert_marker_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (bus_out[STATUS_W-1:0] == STATUS_CODE) && (bus_out[PAD_HI:STATUS_W] == '0));

  // R3: marker word held during a cycle
  assert_marker_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(bus_oe)) |-> $stable(bus_out));

  // R2: idle means quiet strobes and released bus
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ras_n && (cas_n == '1) && !bus_oe && (bus_out == '0)));

  // R10: counter advance after a finished cycle
  assert_addr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done) && !$past(wr_en)) |-> (addr_q == ADDR_W'($past(addr_q) + ADDR_W'(1))));

  // R11: a write always lands
  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> (addr_q == $past(wr_data)));

endmodule

bind cbr_refresh_seq cbr_refresh_seq_chk #(
  .ADDR_W     (ADDR_W),
  .BUS_W      (BUS_W),
  .NUM_CAS    (NUM_CAS),
  .STATUS_W   (STATUS_W),
  .STATUS_CODE(STATUS_CODE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .bus_out  (bus_out),
  .bus_oe   (bus_oe),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .done     (done),
  .addr_q   (addr_q)
);

// File: tb/cbr_refresh_seq_test.sv
module cbr_refresh_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        qtick = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        stretch_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [31:0] bus_out;
  logic        bus_oe;
  logic        ras_n;
  logic [3:0]  cas_n;
  logic        done;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_addr = '0;

  always #4 clk = ~clk;

  cbr_refresh_seq uut (
    .clk(clk), .rst_n(rst_n), .qtick(qtick), .req_valid(req_valid),
    .req_ready(req_ready), .stretch_en(stretch_en), .wr_en(wr_en),
    .wr_data(wr_data), .bus_out(bus_out), .bus_oe(bus_oe),
    .ras_n(ras_n), .cas_n(cas_n), .done(done)
  );

  function automatic logic [31:0] marker(input logic [15:0] a);
    return {a, 12'h000, 4'b0011};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_addr(input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    exp_addr = v;
  endtask

  task automatic run_cycle(input bit st, input bit flip, input bit hold,
                           input bit mid_wr, input logic [15:0] mid_val,
                           input bit end_wr, input logic [15:0] end_val);
    int cnt [3];
    bit seen_done;
    int n;
    logic [31:0] exp_bus;
    cnt[0] = 0; cnt[1] = 0; cnt[2] = 0;
    seen_done = 1'b0;
    n = 0;
    @(negedge clk);
    check(req_ready == 1'b1, "R2 ready when idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; stretch_en = st; qtick = 1'($urandom % 2);
    @(negedge clk);
    req_valid = hold;
    if (flip) stretch_en = ~st;
    exp_bus = marker(exp_addr);
    check(cas_n == 4'h0 && ras_n == 1'b1, "R4 column strobes first",
          {27'd0, ras_n, cas_n}, 32'h10);
    while (!seen_done && n < 100) begin
      if (done) begin
        seen_done = 1'b1;
        check(ras_n == 1'b1 && cas_n == 4'hF, "R9 done with strobes high",
              {27'd0, ras_n, cas_n}, 32'h1F);
        check(cnt[0] == 2, "R5 ticks to row fall", 32'(cnt[0]), 32'd2);
        check(cnt[1] == 4 + int'(st), "R6/R8 ticks both low", 32'(cnt[1]), 32'(4 + int'(st)));
        check(cnt[2] == 2, "R7 ticks to row release", 32'(cnt[2]), 32'd2);
        qtick = 1'b0; req_valid = 1'b0;
        wr_en = end_wr; wr_data = end_val;
      end else begin
        int ph;
        bit q;
        if (cas_n == 4'h0 && ras_n) ph = 0;
        else if (cas_n == 4'h0 && !ras_n) ph = 1;
        else if (cas_n == 4'hF && !ras_n) ph = 2;
        else ph = 3;
        check(ph != 3, "R4 strobe pattern", {27'd0, ras_n, cas_n}, 32'h0);
        check(bus_oe && bus_out == exp_bus, "R3 marker word", bus_out, exp_bus);
        check(!req_ready, "R2 busy not ready", 32'(req_ready), 32'd0);
        if (mid_wr && n == 2) begin
          wr_en = 1'b1; wr_data = mid_val;
        end else begin
          wr_en = 1'b0;
        end
        q = 1'($urandom % 2);
        qtick = q;
        if (q && ph < 3) cnt[ph]++;
      end
      n++;
      @(negedge clk);
    end
    wr_en = 1'b0;
    check(seen_done, "R9 done reached", 32'(seen_done), 32'd1);
    check(!done, "R9 done one clock", 32'(done), 32'd0);
    check(req_ready && !bus_oe && bus_out == 32'd0 && ras_n && cas_n == 4'hF,
          "R2/R3 idle after cycle", bus_out, 32'd0);
    if (end_wr) exp_addr = end_val;
    else if (mid_wr) exp_addr = mid_val + 16'd1;
    else exp_addr = exp_addr + 16'd1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    repeat (4) @(negedge clk);
    check(ras_n && cas_n == 4'hF && !bus_oe && bus_out == 0 && !done && req_ready,
          "R1 reset state", {bus_out[31:5], ras_n, cas_n}, 32'h1F);
    rst_n = 1'b1;
    // R1: counter starts at zero, seen on the first marker word
    run_cycle(0, 0, 0, 0, 16'h0, 0, 16'h0);
    write_addr(16'h1234);                       // R11 plain write
    run_cycle(0, 0, 0, 0, 16'h0, 0, 16'h0);
    run_cycle(1, 0, 0, 0, 16'h0, 0, 16'h0);     // R6 stretched
    run_cycle(0, 1, 0, 0, 16'h0, 0, 16'h0);     // R8 late stretch ignored
    run_cycle(1, 1, 0, 0, 16'h0, 0, 16'h0);     // R8 late drop ignored
    run_cycle(0, 0, 1, 0, 16'h0, 0, 16'h0);     // R2 valid held while busy
    run_cycle(0, 0, 0, 1, 16'hABCD, 0, 16'h0);  // R11 mid-cycle write
    write_addr(16'hFFFF);
    run_cycle(0, 0, 0, 0, 16'h0, 0, 16'h0);     // R10 wrap source
    check(exp_addr == 16'h0000, "R10 wrap model", 32'(exp_addr), 32'd0);
    run_cycle(0, 0, 0, 0, 16'h0, 0, 16'h0);     // R10 shows 0000
    run_cycle(1, 0, 0, 0, 16'h0, 1, 16'h5A5A);  // R11 write vs advance
    run_cycle(0, 0, 0, 0, 16'h0, 0, 16'h0);     // shows 5A5A
    for (int i = 0; i < 24; i++) begin
      if ($urandom % 4 == 0) write_addr(16'($urandom));
      run_cycle(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
                1'($urandom % 3 == 0), 16'($urandom), 1'($urandom % 4 == 0), 16'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule